// File: doc/BRIEF.md
# Cache-Line DMA Request Splitter

This block takes a single DMA transfer (byte address, byte length, direction) and carries it out as a chain of memory transactions, each confined to one cache line. The first transaction starts at the possibly unaligned start address and is cut short at the next line boundary. Every transaction after it starts on a line boundary and covers a full line, or whatever is left of the transfer. Only one transaction is in flight at a time. The next one is presented only after the memory side answers the current one: with an acknowledge for a store, or with a returned line for a load.

Only one transfer is held at a time. While a transfer is active, a new request is refused and leaves the block untouched. Store bytes are fetched through a byte-indexed source window and placed at the in-line offset of the outgoing line. Load bytes are pulled from the returned line and delivered through a byte-indexed sink window. Both windows are indexed by the count of bytes already finished. A one-cycle completion pulse ends the transfer. In that same cycle the block is idle again and can take the next request.

Top module: `dma_line_splitter`

## Requirements
- R1: When the block is idle, `req_valid` raises `req_accept` in the same cycle and the request is latched at the clock edge. While a transfer is active, `req_valid` raises `req_full`, keeps `req_accept` low, and changes neither the transaction sequence nor the completion.
- R2: The first transaction of a transfer has address equal to the start address. Its length is min(length, LINE_BYTES − (start mod LINE_BYTES)).
- R3: Each later transaction starts at start + finished bytes. That address is a multiple of LINE_BYTES, and the length is min(remaining bytes, LINE_BYTES).
- R4: No transaction has zero length, and none extends past the end of the line that holds its address.
- R5: Each transaction presents `mem_store` (1 = store, 0 = load) and `mem_line_addr`, which is `mem_addr` with its low log2(LINE_BYTES) bits cleared.
- R6: `mem_valid` and the transaction fields stay stable until `mem_ready` is high. After a transaction is taken, `mem_valid` stays low until the matching response arrives.
- R7: A store is answered only by `mem_ack` and a load only by `mem_rvalid`. A response of the wrong kind has no effect.
- R8: `wbuf_idx` equals the finished byte count. For a store, byte (off+k) of `mem_wdata` equals byte k of `wbuf_data` for k < `mem_len`, where off = `mem_addr` mod LINE_BYTES. All other bytes of `mem_wdata` are zero.
- R9: On an accepted load response, `rd_valid` is high in the same cycle. `rd_idx` equals the finished count before this chunk, and `rd_len` equals the chunk length. Byte j of `rd_data` equals byte (off+j) of `mem_rdata` for j < `rd_len`, where off is the start offset for the first chunk and 0 for later chunks. Higher bytes are zero.
- R10: `done` is high for the cycle after the response that finishes the transfer. In that cycle `mem_valid` is low and a new request is accepted.
- R11: A zero-length request is accepted, issues no transaction, and raises `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 = store transfer, 0 = load transfer |
| req_accept | output | 1 | Request taken this cycle |
| req_full | output | 1 | Request refused, block busy |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| mem_valid | output | 1 | Transaction presented |
| mem_ready | input | 1 | Memory takes the transaction |
| mem_store | output | 1 | Transaction type, 1 = store |
| mem_addr | output | ADDR_W | Transaction byte address |
| mem_line_addr | output | ADDR_W | Line-aligned address |
| mem_len | output | LEN_W | Transaction byte count |
| mem_wdata | output | LINE_BYTES*8 | Store line, bytes at in-line offset |
| mem_ack | input | 1 | Store acknowledge |
| mem_rvalid | input | 1 | Load line returned |
| mem_rdata | input | LINE_BYTES*8 | Returned line |
| wbuf_idx | output | LEN_W | Source window start index |
| wbuf_data | input | LINE_BYTES*8 | Source bytes from wbuf_idx upward |
| rd_valid | output | 1 | Load bytes delivered |
| rd_idx | output | LEN_W | Sink window start index |
| rd_len | output | LEN_W | Number of delivered bytes |
| rd_data | output | LINE_BYTES*8 | Delivered bytes from byte 0 |

## Verification
The checker enforces several rules on every cycle: line containment and non-zero length of each transaction, line alignment after the first chunk, the line-address relation, holding of fields while stalled, the silence between issue and response, and the progress of the counters. The order of chunk lengths, the byte placement in store lines and extracted load data, the refusal of a second request and of a wrong-kind response, and the back-to-back start after `done` all depend on whole transfers. Only the bench's directed and random scenarios, checked against its own model, can show them.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } dls_state_e;

  // Bytes a chunk may carry: what is left, capped by room to the line end.
  function automatic logic [31:0] fit_len(input logic [31:0] off,
                                          input logic [31:0] rem,
                                          input logic [31:0] line);
    logic [31:0] room;
    room = line - off;
    return (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/dls_chunk.sv
module dls_chunk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic [LEN_W-1:0]              xfer_len,
  input  logic [LEN_W-1:0]              fin_cnt,
  output logic [ADDR_W-1:0]             chunk_addr,
  output logic [ADDR_W-1:0]             chunk_line,
  output logic [$clog2(LINE_BYTES)-1:0] chunk_off,
  output logic [LEN_W-1:0]              chunk_len
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [LEN_W-1:0] remain;

  assign chunk_addr = start_addr + ADDR_W'(fin_cnt);
  assign chunk_off  = chunk_addr[OFF_W-1:0];
  assign chunk_line = {chunk_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign remain     = xfer_len - fin_cnt;
  assign chunk_len  = LEN_W'(dls_pkg::fit_len(32'(chunk_off), 32'(remain),
                                               32'(LINE_BYTES)));
endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              mem_ready,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [LEN_W-1:0]  chunk_len,
  output logic              req_accept,
  output logic              req_full,
  output logic              busy,
  output logic              issuing,
  output logic              issue_fire,
  output logic              resp_fire,
  output logic              done_pulse,
  output logic [ADDR_W-1:0] start_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              write_q,
  output logic [LEN_W-1:0]  issued_q,
  output logic [LEN_W-1:0]  fin_q
);
  import dls_pkg::*;

  dls_state_e state;
  logic       resp_kind;

  assign busy       = (state != ST_IDLE);
  assign issuing    = (state == ST_ISSUE);
  assign req_accept = req_valid && !busy;
  assign req_full   = req_valid && busy;
  assign issue_fire = issuing && mem_ready;
  assign resp_kind  = write_q ? mem_ack : mem_rvalid;
  assign resp_fire  = (state == ST_WAIT) && resp_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      start_q    <= '0;
      len_q      <= '0;
      write_q    <= 1'b0;
      issued_q   <= '0;
      fin_q      <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_accept) begin
            start_q  <= req_addr;
            len_q    <= req_len;
            write_q  <= req_write;
            issued_q <= '0;
            fin_q    <= '0;
            if (req_len == '0) done_pulse <= 1'b1;
            else               state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_ready) begin
            issued_q <= issued_q + chunk_len;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (resp_kind) begin
            fin_q <= issued_q;
            if (issued_q == len_q) begin
              state      <= ST_IDLE;
              done_pulse <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dls_wpack.sv
module dls_wpack #(
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [LEN_W-1:0]              len,
  input  logic [LINE_BYTES*8-1:0]       src,
  output logic [LINE_BYTES*8-1:0]       line
);
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [LINE_BITS-1:0] shifted;
  assign shifted = src << {off, 3'b000};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic keep;
    assign keep = (32'(b) >= 32'(off)) && (32'(b) < 32'(off) + 32'(len));
    assign line[b*8 +: 8] = keep ? shifted[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dls_rextract.sv
module dls_rextract #(
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [LEN_W-1:0]              len,
  input  logic [LINE_BYTES*8-1:0]       line,
  output logic [LINE_BYTES*8-1:0]       dst
);
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [LINE_BITS-1:0] shifted;
  assign shifted = line >> {off, 3'b000};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign dst[b*8 +: 8] = (32'(b) < 32'(len)) ? shifted[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_write,
  output logic                    req_accept,
  output logic                    req_full,
  output logic                    done,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_store,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_line_addr,
  output logic [LEN_W-1:0]        mem_len,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic                    mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  output logic [LEN_W-1:0]        wbuf_idx,
  input  logic [LINE_BYTES*8-1:0] wbuf_data,
  output logic                    rd_valid,
  output logic [LEN_W-1:0]        rd_idx,
  output logic [LEN_W-1:0]        rd_len,
  output logic [LINE_BYTES*8-1:0] rd_data
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // Named internal events, also seen by the bound checker.
  logic              busy_w;
  logic              issuing_w;
  logic              issue_fire_w;
  logic              resp_fire_w;
  logic              first_chunk_w;
  logic [ADDR_W-1:0] start_w;
  logic [LEN_W-1:0]  len_w;
  logic              write_w;
  logic [LEN_W-1:0]  issued_w;
  logic [LEN_W-1:0]  fin_w;
  logic [ADDR_W-1:0] chunk_addr_w;
  logic [ADDR_W-1:0] chunk_line_w;
  logic [OFF_W-1:0]  chunk_off_w;
  logic [LEN_W-1:0]  chunk_len_w;
  logic [LEN_W-1:0]  inflight_w;

  dls_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_write  (req_write),
    .mem_ready  (mem_ready),
    .mem_ack    (mem_ack),
    .mem_rvalid (mem_rvalid),
    .chunk_len  (chunk_len_w),
    .req_accept (req_accept),
    .req_full   (req_full),
    .busy       (busy_w),
    .issuing    (issuing_w),
    .issue_fire (issue_fire_w),
    .resp_fire  (resp_fire_w),
    .done_pulse (done),
    .start_q    (start_w),
    .len_q      (len_w),
    .write_q    (write_w),
    .issued_q   (issued_w),
    .fin_q      (fin_w)
  );

  dls_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_chunk (
    .start_addr (start_w),
    .xfer_len   (len_w),
    .fin_cnt    (fin_w),
    .chunk_addr (chunk_addr_w),
    .chunk_line (chunk_line_w),
    .chunk_off  (chunk_off_w),
    .chunk_len  (chunk_len_w)
  );

  dls_wpack #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_wpack (
    .off  (chunk_off_w),
    .len  (chunk_len_w),
    .src  (wbuf_data),
    .line (mem_wdata)
  );

  assign inflight_w = issued_w - fin_w;

  dls_rextract #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_rext (
    .off  (chunk_off_w),
    .len  (inflight_w),
    .line (mem_rdata),
    .dst  (rd_data)
  );

  assign first_chunk_w = (fin_w == '0);
  assign mem_valid     = issuing_w;
  assign mem_store     = write_w;
  assign mem_addr      = chunk_addr_w;
  assign mem_line_addr = chunk_line_w;
  assign mem_len       = chunk_len_w;
  assign wbuf_idx      = fin_w;
  assign rd_valid      = resp_fire_w && !write_w;
  assign rd_idx        = fin_w;
  assign rd_len        = inflight_w;
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_accept,
  input logic              done,
  input logic              busy,
  input logic              first_chunk,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_line_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic [LEN_W-1:0]  issued,
  input logic [LEN_W-1:0]  fin
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (busy || done));

  assert_later_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !first_chunk) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_no_line_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_len != '0) &&
                   (32'(mem_addr[OFF_W-1:0]) + 32'(mem_len) <= LINE_BYTES)));

  assert_line_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_line_addr[OFF_W-1:0] == '0) &&
                   (mem_line_addr[ADDR_W-1:OFF_W] == mem_addr[ADDR_W-1:OFF_W])));

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

  assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_valid));

  assert_counts_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issued >= fin);
endmodule

bind dma_line_splitter dls_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
) u_dls_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_accept    (req_accept),
  .done          (done),
  .busy          (busy_w),
  .first_chunk   (first_chunk_w),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_line_addr (mem_line_addr),
  .mem_len       (mem_len),
  .issued        (issued_w),
  .fin           (fin_w)
);

// File: tb/dma_line_splitter_bench.sv
module dma_line_splitter_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int LINE   = 64;
  localparam int LBITS  = LINE * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_write = 1'b0;
  logic             req_accept, req_full, done;
  logic             mem_valid, mem_store;
  logic             mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr, mem_line_addr;
  logic [LEN_W-1:0] mem_len;
  logic [LBITS-1:0] mem_wdata;
  logic             mem_ack = 1'b0;
  logic             mem_rvalid = 1'b0;
  logic [LBITS-1:0] mem_rdata = '0;
  logic [LEN_W-1:0] wbuf_idx;
  logic [LBITS-1:0] wbuf_data;
  logic             rd_valid;
  logic [LEN_W-1:0] rd_idx, rd_len;
  logic [LBITS-1:0] rd_data;

  logic [7:0] src [512];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_line_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE))
  u_dma_line_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_accept(req_accept),
    .req_full(req_full), .done(done), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_store(mem_store), .mem_addr(mem_addr),
    .mem_line_addr(mem_line_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wbuf_idx(wbuf_idx), .wbuf_data(wbuf_data), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .rd_len(rd_len), .rd_data(rd_data)
  );

  // Source window: bytes starting at wbuf_idx.
  always_comb begin
    for (int k = 0; k < LINE; k++)
      wbuf_data[k*8 +: 8] = src[(int'(wbuf_idx) + k) % 512];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LBITS-1:0] exp_store_line(int off, int clen, int base);
    logic [LBITS-1:0] v = '0;
    for (int i = 0; i < LINE; i++)
      if (i >= off && i < off + clen) v[i*8 +: 8] = src[(base + i - off) % 512];
    return v;
  endfunction

  function automatic logic [LBITS-1:0] exp_load_bytes(logic [LBITS-1:0] ln, int off, int clen);
    logic [LBITS-1:0] v = '0;
    for (int j = 0; j < clen; j++) v[j*8 +: 8] = ln[(off + j)*8 +: 8];
    return v;
  endfunction

  function automatic logic [LBITS-1:0] rand_line();
    logic [LBITS-1:0] v;
    for (int w = 0; w < LBITS / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One whole transfer, entered and left at a falling edge.
  task automatic run_xfer(input int addr, input int len, input bit wr,
                          input bit poke_full, input bit poke_wrong);
    int fin = 0;
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_write = wr;
    #1;
    chk(req_accept == 1'b1 && req_full == 1'b0, "R1 accept when idle", {62'd0, req_full, req_accept}, 64'd1);
    step();
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R11 zero length done", done, 1);
      chk(mem_valid == 1'b0, "R11 no transaction", mem_valid, 0);
      return;
    end
    while (fin < len) begin
      int cur = addr + fin;
      int off = cur % LINE;
      int clen = ((len - fin) < (LINE - off)) ? (len - fin) : (LINE - off);
      int stall = $urandom_range(0, 2);
      logic [LBITS-1:0] ln;
      for (int s = 0; s < stall; s++) begin
        chk(mem_valid == 1'b1 && mem_addr == ADDR_W'(cur), "R6 hold while stalled", mem_addr, cur);
        step();
      end
      chk(mem_valid == 1'b1, "R6 transaction presented", mem_valid, 1);
      chk(mem_addr == ADDR_W'(cur), fin == 0 ? "R2 first address" : "R3 later address", mem_addr, cur);
      chk(mem_len == LEN_W'(clen), fin == 0 ? "R2 first length" : "R3 later length", mem_len, clen);
      chk(mem_line_addr == ADDR_W'(cur - off) && mem_store == wr, "R5 line address and type",
          {mem_store, mem_line_addr}, {wr, 32'(cur - off)});
      chk(wbuf_idx == LEN_W'(fin), "R8 source index", wbuf_idx, fin);
      if (wr) chk(mem_wdata == exp_store_line(off, clen, fin), "R8 store line placement",
                  mem_wdata[63:0], exp_store_line(off, clen, fin) >> 0);
      mem_ready = 1'b1;
      step();
      mem_ready = 1'b0;
      chk(mem_valid == 1'b0, "R6 silent until response", mem_valid, 0);
      if (poke_full && fin == 0) begin
        req_valid = 1'b1; req_addr = ADDR_W'(addr + 7); req_len = 16'd3; req_write = ~wr;
        #1;
        chk(req_full == 1'b1 && req_accept == 1'b0, "R1 refused while busy", {req_full, req_accept}, 2);
        step();
        req_valid = 1'b0;
        chk(mem_valid == 1'b0 && done == 1'b0, "R1 refusal changes nothing", {mem_valid, done}, 0);
      end
      if (poke_wrong) begin
        if (wr) begin mem_rvalid = 1'b1; mem_rdata = rand_line(); end
        else mem_ack = 1'b1;
        #1;
        chk(rd_valid == 1'b0, "R7 wrong response no delivery", rd_valid, 0);
        step();
        mem_rvalid = 1'b0; mem_ack = 1'b0;
        chk(mem_valid == 1'b0 && done == 1'b0, "R7 wrong response ignored", {mem_valid, done}, 0);
      end
      repeat ($urandom_range(0, 2)) step();
      if (wr) mem_ack = 1'b1;
      else begin
        ln = rand_line();
        mem_rdata = ln; mem_rvalid = 1'b1;
        #1;
        chk(rd_valid == 1'b1 && rd_idx == LEN_W'(fin), "R9 delivery index", rd_idx, fin);
        chk(rd_len == LEN_W'(clen), "R9 delivery length", rd_len, clen);
        chk(rd_data == exp_load_bytes(ln, off, clen), "R9 extracted bytes",
            rd_data[63:0], exp_load_bytes(ln, off, clen) >> 0);
      end
      step();
      mem_ack = 1'b0; mem_rvalid = 1'b0;
      fin += clen;
      if (fin < len) chk(done == 1'b0, "R10 no early done", done, 0);
    end
    chk(done == 1'b1 && mem_valid == 1'b0, "R10 completion pulse", {done, mem_valid}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) src[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(mem_valid == 1'b0 && done == 1'b0 && req_full == 1'b0 && req_accept == 1'b0,
        "R1 reset state", {mem_valid, done, req_full, req_accept}, 0);
    // Directed corners.
    run_xfer(128, 64, 1'b0, 1'b0, 1'b0);   // exactly one aligned line
    run_xfer(60, 4, 1'b1, 1'b0, 1'b0);     // ends on a boundary
    run_xfer(60, 5, 1'b0, 1'b0, 1'b0);     // one byte over
    run_xfer(63, 1, 1'b1, 1'b0, 1'b0);     // last byte of a line
    run_xfer(200, 0, 1'b0, 1'b0, 1'b0);    // zero length
    run_xfer(10, 200, 1'b1, 1'b1, 1'b1);   // store, refusal and wrong response
    run_xfer(37, 150, 1'b0, 1'b1, 1'b1);   // load, refusal and wrong response
    run_xfer(0, 0, 1'b1, 1'b0, 1'b0);      // zero length right after done
    // Random transfers.
    for (int n = 0; n < 60; n++)
      run_xfer($urandom_range(0, 4095), $urandom_range(0, 300), 1'($urandom),
               ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    repeat (2) step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule